// File: doc/BRIEF.md
# USB Host Root-Port State Controller

This block keeps track of the state of the single root port of a USB host. It samples the D+ and D- line levels to notice a device being plugged in or pulled out. It drives a bus reset when software asks for one and times it against an external tick. It also tracks whether the port is suspended or active, and it derives that state from the start-of-frame enable.

Software controls the block through single-cycle write strobes: a set-only VBUS power request, a send-reset command, SOF enable set and clear, and per-flag interrupt clears. The block returns the VBUS enable, the reset drive, the SOF enable, four sticky interrupt flags and a one-cycle pulse that tells the pipe logic to disable and release every pipe when a reset ends. The port state is exposed as a 3-bit code.

When a reset is requested while SOF generation is off, the port is suspended. Completing that reset resumes the bus by itself: the port passes through a one-cycle Resume state, raises a wake-up flag and turns SOF generation on, so frames follow the reset at once.

Top module: `usb_host_port_ctrl`

## Requirements
- R1: After rst_n is released, port_state_o is 0 (Idle), and vbus_en_o, bus_rst_o, sof_en_o, pipe_disable_o and irq_flags_o are all zero. The port_state_o codes are 0 Idle, 1 Suspend, 2 Ready, 3 Bus-reset, 4 Resume.
- R2: A pulse on vbus_req_set_i sets vbus_en_o, and only reset clears it. In Idle with vbus_en_o high, a line level with dp_i or dm_i high moves the port out of Idle on the second clock edge after the line change, and it sets irq_flags_o bit 2 (connect). With vbus_en_o low the port stays in Idle.
- R3: In any state other than Idle, sampled lines with both dp_i and dm_i low send the port to Idle on the second edge after the change, and they set irq_flags_o bit 3 (disconnect).
- R4: sof_en_set_i turns sof_en_o on and sof_en_clr_i turns it off, with clear taking priority. A connected port not in a reset or resume reads Suspend (1) while sof_en_o is low and Ready (2) while it is high, and it changes on the same edge as sof_en_o.
- R5: A pulse on rst_send_i in Suspend or Ready enters Bus-reset on the next edge, and bus_rst_o is high exactly while in Bus-reset. In Idle the pulse has no effect.
- R6: The reset lasts until RST_TICKS cycles with tick_i high have been sampled in Bus-reset. The port leaves on the edge that samples the last of them, and ticks before entry are not counted.
- R7: A completed reset sets irq_flags_o bit 0 (reset sent) and drives pipe_disable_o high for exactly one cycle, in the cycle right after the last tick. If SOF was on when the reset was requested, the port returns to Ready.
- R8: If sof_en_o was low when the reset was requested, completion enters Resume (4) for one cycle, sets sof_en_o and irq_flags_o bit 1 (wake-up), and then goes to Ready.
- R9: A disconnect during Bus-reset aborts it. The port goes to Idle and sets bit 3, but it sets no bit 0 and gives no pipe_disable_o pulse.
- R10: Each interrupt flag stays set until a one is written to the matching bit of irq_clr_i. A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vbus_req_set_i | input | 1 | Strobe: request VBUS power (set-only) |
| rst_send_i | input | 1 | Strobe: send a bus reset |
| sof_en_set_i | input | 1 | Strobe: enable SOF generation |
| sof_en_clr_i | input | 1 | Strobe: disable SOF generation |
| irq_clr_i | input | 4 | Per-flag clear strobes, same bit order as irq_flags_o |
| dp_i | input | 1 | Sampled D+ level |
| dm_i | input | 1 | Sampled D- level |
| tick_i | input | 1 | Reset-length timebase tick |
| vbus_en_o | output | 1 | VBUS power enable |
| bus_rst_o | output | 1 | Drive bus reset; also the self-clearing send-reset bit |
| sof_en_o | output | 1 | SOF generation enable |
| irq_flags_o | output | 4 | Sticky flags: 0 reset sent, 1 wake-up, 2 connect, 3 disconnect |
| pipe_disable_o | output | 1 | One-cycle pulse: disable and release all pipes |
| port_state_o | output | 3 | Port state code |

## Verification
A control strobe takes effect on the first edge after it: SOF changes, entry into Bus-reset and flag clears all appear after that edge. Line changes pass through one sampling register first, so connect and disconnect results appear after the second edge. Reset completion shows up in the cycle after the edge that samples the last tick, and the Resume code and the pipe pulse are visible only in that single cycle. The bench drives and samples on falling edges and waits exactly that many edges before each comparison. It also checks that the state has not moved one edge earlier (still Bus-reset after RST_TICKS-1 ticks, still Idle one edge after a line change).

// File: rtl/usb_port_pkg.sv
package usb_port_pkg;

    typedef enum logic [2:0] {
        PS_IDLE      = 3'd0,
        PS_SUSPEND   = 3'd1,
        PS_READY     = 3'd2,
        PS_BUS_RESET = 3'd3,
        PS_RESUME    = 3'd4
    } port_state_e;

    localparam int NUM_IRQ      = 4;
    localparam int IRQ_RST_SENT = 0;
    localparam int IRQ_WAKEUP   = 1;
    localparam int IRQ_CONNECT  = 2;
    localparam int IRQ_DISCONN  = 3;

    typedef struct packed {
        port_state_e        state;
        logic               vbus;
        logic               sof;
        logic               resume_pend;
        logic [NUM_IRQ-1:0] irq;
        logic               pipe_dis;
    } port_regs_t;

endpackage

// File: rtl/usb_port_linemon.sv
module usb_port_linemon (
    input  logic clk,
    input  logic rst_n,
    input  logic dp_i,
    input  logic dm_i,
    output logic attach_o,
    output logic se0_o
);
    logic [1:0] line_d, line_q;

    always_comb begin
        line_d = {dp_i, dm_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 2'b00;
        else        line_q <= line_d;
    end

    assign attach_o = |line_q;
    assign se0_o    = ~|line_q;
endmodule

// File: rtl/usb_port_rst_timer.sv
module usb_port_rst_timer #(
    parameter int TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        done_o = en_i && tick_i && (cnt_q == LAST);
        if (!en_i)       cnt_d = '0;
        else if (done_o) cnt_d = '0;
        else if (tick_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_count_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    assert_count_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> cnt_q == '0);
endmodule

// File: rtl/usb_host_port_ctrl.sv
module usb_host_port_ctrl
    import usb_port_pkg::*;
#(
    parameter int RST_TICKS = 50
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vbus_req_set_i,
    input  logic               rst_send_i,
    input  logic               sof_en_set_i,
    input  logic               sof_en_clr_i,
    input  logic [NUM_IRQ-1:0] irq_clr_i,
    input  logic               dp_i,
    input  logic               dm_i,
    input  logic               tick_i,
    output logic               vbus_en_o,
    output logic               bus_rst_o,
    output logic               sof_en_o,
    output logic [NUM_IRQ-1:0] irq_flags_o,
    output logic               pipe_disable_o,
    output logic [2:0]         port_state_o
);
    port_regs_t         r_d, r_q;
    logic [NUM_IRQ-1:0] ev;
    logic               attach, se0, rst_done, in_reset;

    usb_port_linemon u_linemon (
        .clk      (clk),
        .rst_n    (rst_n),
        .dp_i     (dp_i),
        .dm_i     (dm_i),
        .attach_o (attach),
        .se0_o    (se0)
    );

    assign in_reset = (r_q.state == PS_BUS_RESET);

    usb_port_rst_timer #(.TICKS(RST_TICKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (in_reset),
        .tick_i (tick_i),
        .done_o (rst_done)
    );

    always_comb begin
        r_d          = r_q;
        r_d.pipe_dis = 1'b0;
        ev           = '0;
        if (vbus_req_set_i) r_d.vbus = 1'b1;
        if (sof_en_set_i)   r_d.sof  = 1'b1;
        if (sof_en_clr_i)   r_d.sof  = 1'b0;

        unique case (r_q.state)
            PS_IDLE: begin
                if (r_q.vbus && attach) begin
                    r_d.state       = r_d.sof ? PS_READY : PS_SUSPEND;
                    ev[IRQ_CONNECT] = 1'b1;
                end
            end
            PS_SUSPEND, PS_READY: begin
                if (se0) begin
                    r_d.state       = PS_IDLE;
                    ev[IRQ_DISCONN] = 1'b1;
                end else if (rst_send_i) begin
                    r_d.state       = PS_BUS_RESET;
                    r_d.resume_pend = ~r_q.sof;
                end else begin
                    r_d.state       = r_d.sof ? PS_READY : PS_SUSPEND;
                end
            end
            PS_BUS_RESET: begin
                if (se0) begin
                    r_d.state       = PS_IDLE;
                    ev[IRQ_DISCONN] = 1'b1;
                end else if (rst_done) begin
                    r_d.pipe_dis     = 1'b1;
                    ev[IRQ_RST_SENT] = 1'b1;
                    if (r_q.resume_pend) begin
                        r_d.state      = PS_RESUME;
                        r_d.sof        = 1'b1;
                        ev[IRQ_WAKEUP] = 1'b1;
                    end else begin
                        r_d.state = r_d.sof ? PS_READY : PS_SUSPEND;
                    end
                end
            end
            PS_RESUME: begin
                if (se0) begin
                    r_d.state       = PS_IDLE;
                    ev[IRQ_DISCONN] = 1'b1;
                end else begin
                    r_d.state = r_d.sof ? PS_READY : PS_SUSPEND;
                end
            end
            default: r_d.state = PS_IDLE;
        endcase

        r_d.irq = (r_q.irq & ~irq_clr_i) | ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state       <= PS_IDLE;
            r_q.vbus        <= 1'b0;
            r_q.sof         <= 1'b0;
            r_q.resume_pend <= 1'b0;
            r_q.irq         <= '0;
            r_q.pipe_dis    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign vbus_en_o      = r_q.vbus;
    assign bus_rst_o      = in_reset;
    assign sof_en_o       = r_q.sof;
    assign irq_flags_o    = r_q.irq;
    assign pipe_disable_o = r_q.pipe_dis;
    assign port_state_o   = r_q.state;

    assert_no_attach_without_vbus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PS_IDLE && !r_q.vbus) |=> r_q.state == PS_IDLE);
    assert_vbus_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.vbus |=> r_q.vbus);
    assert_disconnect_to_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != PS_IDLE && se0) |=> r_q.state == PS_IDLE);
    assert_suspend_means_sof_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PS_SUSPEND) |-> !r_q.sof);
    assert_ready_means_sof_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PS_READY) |-> r_q.sof);
    assert_pipe_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pipe_dis |=> !r_q.pipe_dis);
    assert_pipe_after_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pipe_dis |-> ($past(in_reset) && r_q.irq[IRQ_RST_SENT]));
    assert_resume_sof_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PS_RESUME) |-> (r_q.sof && r_q.irq[IRQ_WAKEUP]));
    assert_resume_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PS_RESUME) |=> r_q.state != PS_RESUME);
endmodule

// File: tb/usb_host_port_ctrl_bench.sv
module usb_host_port_ctrl_bench;
    localparam int N = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vbus_req_set_i = 1'b0, rst_send_i = 1'b0;
    logic       sof_en_set_i = 1'b0, sof_en_clr_i = 1'b0;
    logic [3:0] irq_clr_i = 4'h0;
    logic       dp_i = 1'b0, dm_i = 1'b0, tick_i = 1'b0;
    logic       vbus_en_o, bus_rst_o, sof_en_o, pipe_disable_o;
    logic [3:0] irq_flags_o;
    logic [2:0] port_state_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    usb_host_port_ctrl #(.RST_TICKS(N)) u_usb_host_port_ctrl (
        .clk(clk), .rst_n(rst_n), .vbus_req_set_i(vbus_req_set_i),
        .rst_send_i(rst_send_i), .sof_en_set_i(sof_en_set_i),
        .sof_en_clr_i(sof_en_clr_i), .irq_clr_i(irq_clr_i), .dp_i(dp_i),
        .dm_i(dm_i), .tick_i(tick_i), .vbus_en_o(vbus_en_o),
        .bus_rst_o(bus_rst_o), .sof_en_o(sof_en_o), .irq_flags_o(irq_flags_o),
        .pipe_disable_o(pipe_disable_o), .port_state_o(port_state_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flags();
        irq_clr_i = 4'hF; step(1); irq_clr_i = 4'h0;
    endtask

    task automatic test_reset_state();
        check("R1", "state", port_state_o, 0);
        check("R1", "vbus", vbus_en_o, 0);
        check("R1", "busrst", bus_rst_o, 0);
        check("R1", "sof", sof_en_o, 0);
        check("R1", "flags", irq_flags_o, 0);
        check("R1", "pipe", pipe_disable_o, 0);
    endtask

    task automatic test_attach();
        dp_i = 1'b1; step(3);
        check("R2", "no vbus stays idle", port_state_o, 0);
        rst_send_i = 1'b1; step(1); rst_send_i = 1'b0;
        check("R5", "reset ignored in idle", bus_rst_o, 0);
        vbus_req_set_i = 1'b1; step(1); vbus_req_set_i = 1'b0;
        check("R2", "vbus set", vbus_en_o, 1);
        check("R2", "still idle one edge", port_state_o, 0);
        step(1);
        check("R2", "attached suspend", port_state_o, 1);
        check("R2", "connect flag", irq_flags_o, 4'b0100);
    endtask

    task automatic test_sof();
        sof_en_set_i = 1'b1; step(1); sof_en_set_i = 1'b0;
        check("R4", "sof on", sof_en_o, 1);
        check("R4", "ready", port_state_o, 2);
        sof_en_set_i = 1'b1; sof_en_clr_i = 1'b1; step(1);
        sof_en_set_i = 1'b0; sof_en_clr_i = 1'b0;
        check("R4", "clear wins", sof_en_o, 0);
        check("R4", "suspend", port_state_o, 1);
    endtask

    task automatic run_reset(input int resume);
        rst_send_i = 1'b1; step(1); rst_send_i = 1'b0;
        check("R5", "bus reset", port_state_o, 3);
        check("R5", "busrst out", bus_rst_o, 1);
        for (int i = 0; i < N - 1; i++) begin
            tick_i = 1'b1; step(1); tick_i = 1'b0; step(1);
        end
        check("R6", "still in reset", bus_rst_o, 1);
        tick_i = 1'b1; step(1); tick_i = 1'b0;
        check("R6", "reset ended", bus_rst_o, 0);
        check("R7", "pipe pulse", pipe_disable_o, 1);
        check("R7", "rst sent flag", irq_flags_o[0], 1);
        check("R8", "wake flag", irq_flags_o[1], resume);
        check("R8", "sof after", sof_en_o, 1);
        check("R8", "state", port_state_o, resume ? 4 : 2);
        step(1);
        check("R7", "pipe one cycle", pipe_disable_o, 0);
        check("R8", "ready after", port_state_o, 2);
    endtask

    task automatic test_flags();
        check("R10", "sticky", irq_flags_o, 4'b0111);
        irq_clr_i = 4'b0010; step(1); irq_clr_i = 4'h0;
        check("R10", "one cleared", irq_flags_o, 4'b0101);
        clear_flags();
        check("R10", "all cleared", irq_flags_o, 0);
    endtask

    task automatic test_abort();
        tick_i = 1'b1; step(3); tick_i = 1'b0;
        rst_send_i = 1'b1; step(1); rst_send_i = 1'b0;
        check("R6", "early ticks ignored", bus_rst_o, 1);
        dp_i = 1'b0; dm_i = 1'b0; step(1);
        check("R9", "pipe quiet", pipe_disable_o, 0);
        step(1);
        check("R9", "idle", port_state_o, 0);
        check("R9", "pipe quiet", pipe_disable_o, 0);
        check("R9", "flags", irq_flags_o, 4'b1000);
        clear_flags();
        dm_i = 1'b1; step(2);
        check("R2", "reattach ready", port_state_o, 2);
        dm_i = 1'b0; step(1);
        check("R3", "one edge later", port_state_o, 2);
        step(1);
        check("R3", "disconnect idle", port_state_o, 0);
        check("R3", "disc flag", irq_flags_o, 4'b1100);
    endtask

    initial begin
        step(3); rst_n = 1'b1; step(1);
        test_reset_state();
        test_attach();
        test_sof();
        run_reset(1);
        test_flags();
        run_reset(0);
        clear_flags();
        test_abort();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected below 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule